// File: doc/BRIEF.md
# Set-Clear-Toggle Control Register Bank

This block holds a parameterized number of 32-bit control words behind a simple memory-mapped access port. Each word is reached through a 16-byte window that holds four word-sized aliases. One alias replaces the stored word. The other three merge the written data into it by OR, AND-NOT or XOR. Software can therefore raise, drop or invert individual control bits with a single write, without a read-modify-write sequence that another agent could interleave with.

Every access is a single cycle on the request side. One cycle later a response comes back: a valid strobe, an error flag, and the read data for reads. Only aligned, full-word accesses are accepted. An access outside the populated part of the window space is refused. A synchronous reset clears the whole bank.

Top module: `scb_bank`

## Requirements
- R1: The register index is `acc_addr[ADDR_W-1:4]`, so register i answers at byte offsets 16*i through 16*i+15. A write changes at most one register.
- R2: A write at window offset 0x0 (`acc_addr[3:0]` = 0) replaces the stored word with `acc_wdata`.
- R3: A write at window offset 0x4 ORs `acc_wdata` into the stored word.
- R4: A write at window offset 0x8 clears the bits that are 1 in `acc_wdata` (stored AND NOT data).
- R5: A write at window offset 0xC inverts the bits that are 1 in `acc_wdata` (stored XOR data).
- R6: A read at any of the four offsets of a window returns the stored word and leaves every register unchanged.
- R7: An access with `acc_addr[1:0]` not 0, or with `acc_be` not 4'b1111, returns `rsp_err`=1 with `rsp_rdata`=0, and changes no register.
- R8: An access whose index is NUM_REGS or above returns `rsp_err`=1 with `rsp_rdata`=0, and changes no register. ADDR_W is clog2(NUM_REGS)+5, so the upper half of the index space lies beyond the bank.
- R9: Each access with `acc_en`=1 produces `rsp_valid`=1 on the next cycle, and no response appears without one. `rsp_rdata` is 0 for writes.
- R10: A write takes effect at the clock edge that samples it, so a read issued in the next cycle returns the new value.
- R11: A synchronous reset (`rst_n`=0 at a clock edge) sets every register and `rsp_valid`, `rsp_err` and `rsp_rdata` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_en | input | 1 | Access request for this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address; [3:0] select the alias |
| acc_wdata | input | 32 | Write data |
| acc_be | input | 4 | Byte enables; must be all ones |
| rsp_valid | output | 1 | Response strobe, one cycle after the access |
| rsp_err | output | 1 | Access was refused |
| rsp_rdata | output | 32 | Read data; zero for writes and errors |

## Verification
The bench targets alias decoding. A design that swaps the set and clear aliases, or that treats the clear alias as a plain write, leaves the wrong bits in the model comparison after chains of merge writes on the same register. It also targets the refusal paths. A misaligned address, a partial byte enable or an index past the bank must not reach storage; a leaky check shows up as a later read that differs from the model, or as nonzero data on a refused access. Back-to-back write-then-read pairs expose a write that lands a cycle late. A mid-run reset followed by a sweep of reads shows any register that is left out of the clear.

// File: rtl/scb_pkg.sv
package scb_pkg;
  localparam int WORD_W   = 32;
  localparam int BE_W     = WORD_W / 8;
  localparam int WIN_BITS = 4;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_FLIP = 2'd3
  } bitop_e;

  // Alias offset within the 16-byte window picks the merge operation.
  function automatic bitop_e op_of_offset(input logic [WIN_BITS-1:0] low);
    return bitop_e'(low[3:2]);
  endfunction

  function automatic logic [WORD_W-1:0] merge_word(
      input bitop_e            op,
      input logic [WORD_W-1:0] cur,
      input logic [WORD_W-1:0] d);
    logic [WORD_W-1:0] res;
    unique case (op)
      OP_LOAD: res = d;
      OP_SET:  res = cur | d;
      OP_CLR:  res = cur & ~d;
      default: res = cur ^ d;
    endcase
    return res;
  endfunction

  function automatic logic word_aligned(input logic [1:0] low2,
                                        input logic [BE_W-1:0] be);
    return (low2 == 2'b00) && (&be);
  endfunction
endpackage

// File: rtl/scb_decode.sv
module scb_decode
  import scb_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = 4,
  parameter int ADDR_W   = 9
) (
  input  logic                acc_en,
  input  logic                acc_we,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic [BE_W-1:0]     acc_be,
  output logic [IDX_W-1:0]    idx,
  output bitop_e              op,
  output logic                bad_align,
  output logic                bad_range,
  output logic [NUM_REGS-1:0] wr_sel
);
  localparam int SEL_W = ADDR_W - WIN_BITS;
  localparam logic [SEL_W-1:0] LIMIT = SEL_W'(NUM_REGS);

  logic [SEL_W-1:0] idx_full;
  logic             wr_ok;

  assign idx_full  = acc_addr[ADDR_W-1:WIN_BITS];
  assign idx       = idx_full[IDX_W-1:0];
  assign op        = op_of_offset(acc_addr[WIN_BITS-1:0]);
  assign bad_align = !word_aligned(acc_addr[1:0], acc_be);
  assign bad_range = (idx_full >= LIMIT);
  assign wr_ok     = acc_en && acc_we && !bad_align && !bad_range;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign wr_sel[i] = wr_ok && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/scb_reg_file.sv
module scb_reg_file
  import scb_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_REGS-1:0]              wr_sel,
  input  bitop_e                           op,
  input  logic [WORD_W-1:0]                wdata,
  output logic [NUM_REGS-1:0][WORD_W-1:0]  regs_q
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs_q[i] <= '0;
      end else if (wr_sel[i]) begin
        regs_q[i] <= merge_word(op, regs_q[i], wdata);
      end
    end
  end
endmodule

// File: rtl/scb_rsp.sv
module scb_rsp
  import scb_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            acc_en,
  input  logic                            acc_we,
  input  logic                            acc_bad,
  input  logic [IDX_W-1:0]                idx,
  input  logic [NUM_REGS-1:0][WORD_W-1:0] regs_q,
  output logic                            rsp_valid,
  output logic                            rsp_err,
  output logic [WORD_W-1:0]               rsp_rdata
);
  logic [WORD_W-1:0] rd_word;

  always_comb begin
    rd_word = '0;
    if (acc_en && !acc_we && !acc_bad) begin
      rd_word = regs_q[idx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc_en;
      rsp_err   <= acc_en && acc_bad;
      rsp_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/scb_bank.sv
module scb_bank
  import scb_pkg::*;
#(
  parameter  int NUM_REGS = 16,
  localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int ADDR_W   = IDX_W + WIN_BITS + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [31:0]       acc_wdata,
  input  logic [3:0]        acc_be,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata
);
  // Named internal events, visible to the bound checker.
  logic [IDX_W-1:0]                dec_idx;
  bitop_e                          dec_op;
  logic                            dec_bad_align;
  logic                            dec_bad_range;
  logic                            dec_bad;
  logic [NUM_REGS-1:0]             wr_sel;
  logic [NUM_REGS-1:0][WORD_W-1:0] regs_q;

  scb_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_dec (
    .acc_en    (acc_en),
    .acc_we    (acc_we),
    .acc_addr  (acc_addr),
    .acc_be    (acc_be),
    .idx       (dec_idx),
    .op        (dec_op),
    .bad_align (dec_bad_align),
    .bad_range (dec_bad_range),
    .wr_sel    (wr_sel)
  );

  assign dec_bad = dec_bad_align || dec_bad_range;

  scb_reg_file #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_sel (wr_sel),
    .op     (dec_op),
    .wdata  (acc_wdata),
    .regs_q (regs_q)
  );

  scb_rsp #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (acc_en),
    .acc_we    (acc_we),
    .acc_bad   (dec_bad),
    .idx       (dec_idx),
    .regs_q    (regs_q),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: rtl/scb_bank_chk.sv
module scb_bank_chk
  import scb_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int ADDR_W   = 9
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            acc_en,
  input logic                            acc_we,
  input logic [ADDR_W-1:0]               acc_addr,
  input logic [3:0]                      acc_be,
  input logic                            rsp_valid,
  input logic                            rsp_err,
  input logic [31:0]                     rsp_rdata,
  input logic [NUM_REGS-1:0]             wr_sel,
  input logic [NUM_REGS-1:0][WORD_W-1:0] regs_q
);
  localparam int SEL_W = ADDR_W - WIN_BITS;

  logic misaligned;
  logic beyond;
  assign misaligned = (acc_addr[1:0] != 2'b00) || (acc_be != 4'hF);
  assign beyond     = (int'(acc_addr[ADDR_W-1:WIN_BITS]) >= NUM_REGS);

  p_one_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));

  p_read_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_we) |=> $stable(regs_q));

  p_align_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && misaligned) |=> (rsp_err && rsp_rdata == '0));

  p_align_nowr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    misaligned |-> (wr_sel == '0));

  p_range_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && beyond) |=> (rsp_err && rsp_rdata == '0));

  p_range_nowr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    beyond |-> (wr_sel == '0));

  p_rsp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> rsp_valid);

  p_rsp_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> (!rsp_valid && !rsp_err));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> $stable(regs_q));

  p_reset_clear_r11: assert property (@(posedge clk)
    !rst_n |=> (!rsp_valid && !rsp_err && rsp_rdata == '0 && regs_q == '0));
endmodule

bind scb_bank scb_bank_chk #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_en    (acc_en),
  .acc_we    (acc_we),
  .acc_addr  (acc_addr),
  .acc_be    (acc_be),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata),
  .wr_sel    (wr_sel),
  .regs_q    (regs_q)
);

// File: tb/scb_bank_tb_top.sv
module scb_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NREG   = 16;
  localparam int IW     = $clog2(NREG);
  localparam int AW     = IW + 5;
  localparam int SEED   = 32'h5eed_c0de;
  localparam int N_RAND = 600;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          acc_en;
  logic          acc_we;
  logic [AW-1:0] acc_addr;
  logic [31:0]   acc_wdata;
  logic [3:0]    acc_be;
  logic          rsp_valid;
  logic          rsp_err;
  logic [31:0]   rsp_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] model [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  scb_bank #(.NUM_REGS(NREG)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_be(acc_be),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench's own statement of the alias rules: 0x0 load, 0x4 OR, 0x8 AND-NOT, 0xC XOR.
  function automatic logic [31:0] expect_merge(input logic [3:0] off,
                                               input logic [31:0] old,
                                               input logic [31:0] d);
    if (off == 4'h4) return old | d;
    if (off == 4'h8) return old & ~d;
    if (off == 4'hC) return old ^ d;
    return d;
  endfunction

  function automatic bit refused(input logic [AW-1:0] a, input logic [3:0] be);
    return (a[1:0] != 2'b00) || (be != 4'hF) || (int'(a[AW-1:4]) >= NREG);
  endfunction

  // Drive at a falling edge; the response is sampled one falling edge later.
  task automatic access(input bit we, input logic [AW-1:0] a,
                        input logic [31:0] d, input logic [3:0] be,
                        input string req);
    bit bad;
    logic [31:0] exp_rd;
    bad = refused(a, be);
    exp_rd = '0;
    if (!we && !bad) exp_rd = model[int'(a[AW-1:4])];
    acc_en = 1'b1; acc_we = we; acc_addr = a; acc_wdata = d; acc_be = be;
    @(posedge clk);
    @(negedge clk);
    acc_en = 1'b0;
    if (we && !bad)
      model[int'(a[AW-1:4])] = expect_merge(a[3:0], model[int'(a[AW-1:4])], d);
    check(rsp_valid === 1'b1, {req, " R9 valid"}, 32'(rsp_valid), 32'd1);
    check(rsp_err === bad, {req, " err"}, 32'(rsp_err), 32'(bad));
    check(rsp_rdata === exp_rd, {req, " rdata"}, rsp_rdata, exp_rd);
  endtask

  function automatic logic [AW-1:0] mk_addr(input int idx, input logic [3:0] off);
    return {idx[IW:0], off};
  endfunction

  task automatic sweep_reads(input string req);
    for (int i = 0; i < NREG; i++) access(1'b0, mk_addr(i, 4'h0), '0, 4'hF, req);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; acc_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(rsp_valid === 1'b0, "R11 valid low in reset", 32'(rsp_valid), 0);
    check(rsp_rdata === '0, "R11 rdata zero in reset", rsp_rdata, 0);
    rst_n = 1'b1;
    for (int i = 0; i < NREG; i++) model[i] = '0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    logic [31:0] dummy;
    rst_n = 1'b0; acc_en = 1'b0; acc_we = 1'b0;
    acc_addr = '0; acc_wdata = '0; acc_be = 4'hF;
    dummy = $urandom(SEED);
    for (int i = 0; i < NREG; i++) model[i] = 32'hDEAD_BEEF;
    repeat (2) @(posedge clk);
    do_reset();
    sweep_reads("R11 cleared after reset");
    // R2 .. R5 directed chain on one register, read through each alias (R6)
    access(1'b1, mk_addr(3, 4'h0), 32'hF0F0_00FF, 4'hF, "R2 load");
    access(1'b0, mk_addr(3, 4'h4), '0, 4'hF, "R6 R10 read set alias");
    access(1'b1, mk_addr(3, 4'h4), 32'h0000_0F00, 4'hF, "R3 set");
    access(1'b0, mk_addr(3, 4'h8), '0, 4'hF, "R3 R6 read clr alias");
    access(1'b1, mk_addr(3, 4'h8), 32'hF000_000F, 4'hF, "R4 clear");
    access(1'b0, mk_addr(3, 4'hC), '0, 4'hF, "R4 R6 read flip alias");
    access(1'b1, mk_addr(3, 4'hC), 32'hFFFF_FFFF, 4'hF, "R5 toggle");
    access(1'b0, mk_addr(3, 4'h0), '0, 4'hF, "R5 read back");
    // R1 neighbours untouched
    access(1'b0, mk_addr(2, 4'h0), '0, 4'hF, "R1 neighbour low");
    access(1'b0, mk_addr(4, 4'h0), '0, 4'hF, "R1 neighbour high");
    access(1'b1, mk_addr(NREG-1, 4'h4), 32'h8000_0001, 4'hF, "R1 last reg");
    access(1'b0, mk_addr(NREG-1, 4'h0), '0, 4'hF, "R1 last reg read");
    // R7 refusals, then read target to show no change
    access(1'b1, mk_addr(3, 4'h1), 32'h1234_5678, 4'hF, "R7 offset misaligned");
    access(1'b1, mk_addr(3, 4'h0), 32'h1234_5678, 4'h7, "R7 partial strobe");
    access(1'b0, mk_addr(3, 4'h2), '0, 4'hF, "R7 misaligned read");
    access(1'b0, mk_addr(3, 4'h0), '0, 4'hF, "R7 target unchanged");
    // R8 beyond the bank; index NREG would alias reg 0 if truncated
    access(1'b1, mk_addr(NREG, 4'h0), 32'hAAAA_5555, 4'hF, "R8 write past bank");
    access(1'b0, mk_addr(NREG, 4'h0), '0, 4'hF, "R8 read past bank");
    access(1'b0, mk_addr(0, 4'h0), '0, 4'hF, "R8 reg0 unchanged");
    // Random mix, back-to-back
    for (int n = 0; n < N_RAND; n++) begin
      int idx;
      logic [3:0] off;
      logic [3:0] be;
      idx = ($urandom % 8 == 0) ? NREG + ($urandom % NREG) : $urandom % NREG;
      off = {2'($urandom), 2'b00};
      if ($urandom % 10 == 0) off[1:0] = 2'($urandom);
      be = ($urandom % 10 == 0) ? 4'($urandom) : 4'hF;
      access(1'($urandom), mk_addr(idx, off), $urandom, be, "R1-9 random");
    end
    sweep_reads("R6 final state");
    do_reset();
    sweep_reads("R11 cleared after mid-run reset");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule